// File: doc/BRIEF.md
# Rotating Multi-FIFO Page Transfer Engine

This block moves one flash page of captured samples from a bank of parallel capture FIFOs onto an 8-bit flash data bus, with no processor involvement once a transfer is under way. Software first arms the engine with an enable command, then fires a start strobe once per page. The engine visits the FIFOs in a fixed rotating order, one FIFO per byte slot, so every page holds the channels interleaved in a known pattern. It never lets the reads drift apart from the flash writes: each FIFO read strobe is issued in the same cycle as exactly one flash write strobe.

The capture FIFOs are show-ahead: a FIFO's head byte is valid whenever its empty flag is low, and a read strobe consumes it at the clock edge. If the FIFO whose turn it is runs dry, the engine waits on that FIFO rather than moving on. At the end of each page it gives a one-cycle done pulse. It also turns the rising edge of the FIFO half-full flag into a one-cycle interrupt request. Each such interrupt is serviced by a fixed batch of page transfers, and the engine marks the last page of that batch.

Top module: `rr_page_mover`

## Requirements
- R1: The enable flag `dma_en` is set by a command with `cmd_code` 2'b01, cleared by a command with `cmd_code` 2'b10, and cleared by reset. Other codes and cycles without `cmd_valid` leave it unchanged. A start strobe given while the flag is clear has no effect.
- R2: A start strobe given while the flag is set and the engine is idle begins exactly one transfer, and `busy` is high from the next cycle. A start strobe given while `busy` is high is ignored.
- R3: A transfer makes exactly PAGE_BYTES (default 2048) write strobes. No strobe occurs while `busy` is low.
- R4: Within a transfer, byte k is taken from FIFO k mod NUM_SRC, so the order starts at FIFO 0 on every transfer. `fifo_rd` bit i selects FIFO i, whose byte sits at `fifo_data[i*DATA_W +: DATA_W]`. `flash_io` carries that FIFO's head byte during the strobe.
- R5: `flash_we` is high in exactly the cycles in which exactly one `fifo_rd` bit is high. No more than one `fifo_rd` bit is ever high.
- R6: `done` is high for one cycle. That cycle directly follows the cycle of the final write strobe, and in it `busy` is already low.
- R7: While the FIFO whose turn it is signals empty, no strobe is issued and `busy` stays high. When data arrives, the transfer resumes at that same FIFO, with no byte skipped and none repeated.
- R8: `irq` pulses high for one cycle, one cycle after `fifo_half_full` rises. A half-full level held high does not raise it again.
- R9: `batch_done` is high together with `done` on the PAGES_PER_IRQ-th (default 8) completed page counted since reset or since the last `irq`. It is low at all other times.
- R10: After reset, `dma_en`, `busy`, `done`, `batch_done`, `irq`, `flash_we` and all `fifo_rd` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command valid for one cycle |
| cmd_code | input | 2 | Host command: 01 arm, 10 disarm |
| start | input | 1 | Host start strobe for one page transfer |
| fifo_empty | input | NUM_SRC | Empty flag of each capture FIFO |
| fifo_data | input | NUM_SRC*DATA_W | Head byte of each capture FIFO, FIFO i at slice i |
| fifo_half_full | input | 1 | Capture FIFO half-full flag |
| fifo_rd | output | NUM_SRC | Read strobe of each capture FIFO |
| flash_we | output | 1 | Flash write strobe, paired with the FIFO read |
| flash_io | output | DATA_W | Byte driven to the flash data bus |
| dma_en | output | 1 | Enable flag |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| batch_done | output | 1 | End of the last page of an interrupt batch |
| irq | output | 1 | One-cycle interrupt request on half-full rise |

## Verification
The bench builds the engine at its default sizes: four FIFOs, 8-bit bytes, 2048-byte pages and eight pages per interrupt. This means full-length pages and a whole interrupt batch are exercised, not a shrunk stand-in. Each byte is tagged with its FIFO number and its position in that FIFO, so any slip in the rotation, a skipped byte or a repeated byte shows up as a data mismatch. The stall cases starve the engine before its first byte and again partway into a rotation round. The batch case takes an interrupt after three pages, so a counter that was not restarted would flag the wrong page.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_ARM     = 2'b01,
        CMD_DISARM  = 2'b10,
        CMD_RSVD    = 2'b11
    } host_cmd_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_MOVE = 1'b1
    } seq_state_e;

    // Per-cycle strobe information from the rotator to the sequencer.
    typedef struct packed {
        logic fire;
        logic stalled;
    } xfer_step_t;

    // Width of an index able to hold values 0..n-1 (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pdma_host_ctrl.sv
module pdma_host_ctrl
    import pdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       start,
    input  logic       busy,
    input  logic       half_full,
    output logic       armed,
    output logic       start_ok,
    output logic       irq
);

    host_cmd_e cmd;
    logic      armed_q;
    logic      hf_q;
    logic      irq_q;

    assign cmd = host_cmd_e'(cmd_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (cmd_valid) begin
            case (cmd)
                CMD_ARM:    armed_q <= 1'b1;
                CMD_DISARM: armed_q <= 1'b0;
                default:    armed_q <= armed_q;
            endcase
        end
    end

    // Edge detector on the half-full flag gives a single request per rise.
    always_ff @(posedge clk) begin
        if (rst) begin
            hf_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            hf_q  <= half_full;
            irq_q <= half_full & ~hf_q;
        end
    end

    assign armed    = armed_q;
    assign start_ok = start & armed_q & ~busy;
    assign irq      = irq_q;

endmodule

// File: rtl/pdma_rotator.sv
module pdma_rotator
    import pdma_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      active,
    input  logic [NUM_SRC-1:0]        fifo_empty,
    input  logic [NUM_SRC*DATA_W-1:0] fifo_data,
    output logic [NUM_SRC-1:0]        fifo_rd,
    output logic                      flash_we,
    output logic [DATA_W-1:0]         flash_io,
    output xfer_step_t                step
);

    localparam int SEL_W = idx_width(NUM_SRC);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(NUM_SRC - 1);

    logic [SEL_W-1:0]  sel_q;
    logic              head_ready;
    logic              fire;
    logic [DATA_W-1:0] head_byte;

    always_comb begin
        head_ready = ~fifo_empty[sel_q];
        head_byte  = fifo_data[sel_q*DATA_W +: DATA_W];
    end

    assign fire = active & head_ready;

    // One read strobe per FIFO, each qualified by the shared fire signal.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rd
        assign fifo_rd[g] = fire & (sel_q == SEL_W'(g));
    end

    assign flash_we = fire;
    assign flash_io = fire ? head_byte : '0;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            sel_q <= '0;
        end else if (fire) begin
            sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
        end
    end

    assign step.fire    = fire;
    assign step.stalled = active & ~head_ready;

endmodule

// File: rtl/pdma_page_seq.sv
module pdma_page_seq
    import pdma_pkg::*;
#(
    parameter int PAGE_BYTES    = 2048,
    parameter int PAGES_PER_IRQ = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_ok,
    input  xfer_step_t step,
    input  logic       batch_clear,
    output logic       busy,
    output logic       done,
    output logic       batch_done
);

    localparam int CNT_W   = idx_width(PAGE_BYTES);
    localparam int BATCH_W = idx_width(PAGES_PER_IRQ);
    localparam logic [CNT_W-1:0]   CNT_LAST   = CNT_W'(PAGE_BYTES - 1);
    localparam logic [BATCH_W-1:0] BATCH_LAST = BATCH_W'(PAGES_PER_IRQ - 1);

    seq_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BATCH_W-1:0] batch_q;
    logic               done_q;
    logic               batch_done_q;
    logic               last_byte;

    assign last_byte = (state_q == SEQ_MOVE) & step.fire & (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        state_q <= SEQ_MOVE;
                        cnt_q   <= '0;
                    end
                end
                SEQ_MOVE: begin
                    if (last_byte) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else if (step.fire) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Pages finished within the current interrupt batch.
    always_ff @(posedge clk) begin
        if (rst) begin
            batch_q      <= '0;
            batch_done_q <= 1'b0;
        end else begin
            batch_done_q <= last_byte & (batch_q == BATCH_LAST);
            if (batch_clear) begin
                batch_q <= '0;
            end else if (last_byte) begin
                batch_q <= (batch_q == BATCH_LAST) ? '0 : batch_q + 1'b1;
            end
        end
    end

    assign busy       = (state_q == SEQ_MOVE);
    assign done       = done_q;
    assign batch_done = batch_done_q;

endmodule

// File: rtl/rr_page_mover.sv
module rr_page_mover
    import pdma_pkg::*;
#(
    parameter int NUM_SRC       = 4,
    parameter int DATA_W        = 8,
    parameter int PAGE_BYTES    = 2048,
    parameter int PAGES_PER_IRQ = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_code,
    input  logic                      start,
    input  logic [NUM_SRC-1:0]        fifo_empty,
    input  logic [NUM_SRC*DATA_W-1:0] fifo_data,
    input  logic                      fifo_half_full,
    output logic [NUM_SRC-1:0]        fifo_rd,
    output logic                      flash_we,
    output logic [DATA_W-1:0]         flash_io,
    output logic                      dma_en,
    output logic                      busy,
    output logic                      done,
    output logic                      batch_done,
    output logic                      irq
);

    logic       start_ok;
    logic       busy_w;
    logic       irq_w;
    xfer_step_t step;

    pdma_host_ctrl u_host (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .start     (start),
        .busy      (busy_w),
        .half_full (fifo_half_full),
        .armed     (dma_en),
        .start_ok  (start_ok),
        .irq       (irq_w)
    );

    pdma_rotator #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W)
    ) u_rot (
        .clk        (clk),
        .rst        (rst),
        .restart    (start_ok),
        .active     (busy_w),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .flash_we   (flash_we),
        .flash_io   (flash_io),
        .step       (step)
    );

    pdma_page_seq #(
        .PAGE_BYTES    (PAGE_BYTES),
        .PAGES_PER_IRQ (PAGES_PER_IRQ)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_ok    (start_ok),
        .step        (step),
        .batch_clear (irq_w),
        .busy        (busy_w),
        .done        (done),
        .batch_done  (batch_done)
    );

    assign busy = busy_w;
    assign irq  = irq_w;

endmodule

// File: rtl/rr_page_mover_chk.sv
module rr_page_mover_chk #(
    parameter int NUM_SRC    = 4,
    parameter int PAGE_BYTES = 2048
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [NUM_SRC-1:0] fifo_empty,
    input logic               fifo_half_full,
    input logic [NUM_SRC-1:0] fifo_rd,
    input logic               flash_we,
    input logic               dma_en,
    input logic               busy,
    input logic               done,
    input logic               batch_done,
    input logic               irq
);

    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W = $clog2(PAGE_BYTES + 1);

    logic [SEL_W-1:0] exp_ch;
    logic [CNT_W-1:0] seen;

    // Independent tracking of the FIFO whose turn it is and of bytes per page.
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            exp_ch <= '0;
        end else if (flash_we) begin
            exp_ch <= (exp_ch == SEL_W'(NUM_SRC - 1)) ? '0 : exp_ch + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || done) begin
            seen <= '0;
        end else if (flash_we) begin
            seen <= seen + 1'b1;
        end
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(dma_en) && $past(start))); // R1

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> busy); // R3

    AST_PAGE_LENGTH: assert property (@(posedge clk) disable iff (rst)
        done |-> (seen == CNT_W'(PAGE_BYTES))); // R3

    AST_ROTATION_ORDER: assert property (@(posedge clk) disable iff (rst)
        flash_we |-> (fifo_rd == (NUM_SRC'(1) << exp_ch))); // R4

    AST_PAIRED_STROBES: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fifo_rd) && (flash_we == ($countones(fifo_rd) == 1))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(flash_we) && !busy)); // R6

    AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd & fifo_empty) == '0); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !flash_we) |=> busy); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R8

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(fifo_half_full)); // R8

    AST_BATCH_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        batch_done |-> done); // R9

endmodule

bind rr_page_mover rr_page_mover_chk #(
    .NUM_SRC    (NUM_SRC),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .fifo_empty     (fifo_empty),
    .fifo_half_full (fifo_half_full),
    .fifo_rd        (fifo_rd),
    .flash_we       (flash_we),
    .dma_en         (dma_en),
    .busy           (busy),
    .done           (done),
    .batch_done     (batch_done),
    .irq            (irq)
);

// File: tb/rr_page_mover_test.sv
module rr_page_mover_test;

    localparam int NSRC = 4;
    localparam int DW   = 8;
    localparam int PAGE = 2048;
    localparam int PPI  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                 cmd_valid = 1'b0;
    logic [1:0]           cmd_code  = 2'b00;
    logic                 start     = 1'b0;
    logic [NSRC-1:0]      fifo_empty = '1;
    logic [NSRC*DW-1:0]   fifo_data  = '0;
    logic                 half_full  = 1'b0;
    logic [NSRC-1:0]      fifo_rd;
    logic                 flash_we;
    logic [DW-1:0]        flash_io;
    logic                 dma_en, busy, done, batch_done, irq;

    rr_page_mover #(
        .NUM_SRC(NSRC), .DATA_W(DW), .PAGE_BYTES(PAGE), .PAGES_PER_IRQ(PPI)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .start(start), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_half_full(half_full), .fifo_rd(fifo_rd), .flash_we(flash_we),
        .flash_io(flash_io), .dma_en(dma_en), .busy(busy), .done(done),
        .batch_done(batch_done), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] chq [NSRC][$];
    logic [7:0] expq [$];
    int slot = 0;

    logic [NSRC-1:0] rd_seen = '0;
    int  page_strobes  = 0;
    int  total_strobes = 0;
    int  done_count    = 0;
    int  irq_count     = 0;
    bit  prev_we       = 1'b0;
    bit  prev_done     = 1'b0;
    bit  last_batch    = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic refresh();
        for (int c = 0; c < NSRC; c++) begin
            fifo_empty[c] = (chq[c].size() == 0);
            fifo_data[c*DW +: DW] = (chq[c].size() != 0) ? chq[c][0] : 8'h00;
        end
    endtask

    // Driver: fills FIFOs in rotation order and records the expected flash bytes.
    task automatic load_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            int c = slot % NSRC;
            logic [7:0] v = {c[1:0], 6'(slot / NSRC)};
            chq[c].push_back(v);
            expq.push_back(v);
            slot++;
        end
        refresh();
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(input logic [1:0] code);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_code = code;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_code = 2'b00;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input int k);
        while (done_count < k) @(posedge clk);
        #1;
    endtask

    // FIFO model: consume the head bytes strobed at the previous edge.
    always @(posedge clk) begin
        #1;
        for (int c = 0; c < NSRC; c++) begin
            if (rd_seen[c] && chq[c].size() != 0) void'(chq[c].pop_front());
        end
        refresh();
    end

    // Monitor: scoreboard compare of every flash byte and page-level checks.
    always @(negedge clk) begin
        if (rst) begin
            rd_seen = '0;
        end else begin
            rd_seen = fifo_rd;
            if (flash_we) begin
                logic [7:0] e;
                check(fifo_rd == NSRC'(1 << (page_strobes % NSRC)), "R4",
                      "read strobe of FIFO in turn", int'(fifo_rd),
                      1 << (page_strobes % NSRC));
                check($countones(fifo_rd) == 1, "R5", "read strobes paired with write",
                      $countones(fifo_rd), 1);
                check(busy, "R3", "strobe only while busy", int'(busy), 1);
                if (expq.size() == 0) begin
                    check(1'b0, "R7", "unexpected extra byte", int'(flash_io), -1);
                end else begin
                    e = expq.pop_front();
                    check(flash_io == e, "R4", "flash byte", int'(flash_io), int'(e));
                end
                page_strobes++;
                total_strobes++;
            end else begin
                check(fifo_rd == '0, "R5", "read strobe without write", int'(fifo_rd), 0);
            end
            if (done) begin
                check(page_strobes == PAGE, "R3", "bytes per page", page_strobes, PAGE);
                check(prev_we, "R6", "done follows final strobe", int'(prev_we), 1);
                check(!busy, "R6", "busy low with done", int'(busy), 0);
                check(!prev_done, "R6", "done single cycle", int'(prev_done), 0);
                last_batch = batch_done;
                page_strobes = 0;
                done_count++;
            end
            if (batch_done && !done)
                check(1'b0, "R9", "batch_done without done", 1, 0);
            if (irq) irq_count++;
            prev_we   = flash_we;
            prev_done = done;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        refresh();
        tick(4);
        @(negedge clk);
        // R10: reset state
        check(!dma_en && !busy && !done && !batch_done && !irq, "R10",
              "status outputs in reset", int'({dma_en, busy, done, batch_done, irq}), 0);
        check(!flash_we && fifo_rd == '0, "R10", "strobes in reset",
              int'({flash_we, fifo_rd}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        tick(2);

        // R1: start ignored while not armed, with a full page waiting
        load_bytes(PAGE);
        pulse_start();
        tick(10);
        check(!busy, "R1", "start ignored when disarmed", int'(busy), 0);
        check(total_strobes == 0, "R1", "no strobes when disarmed", total_strobes, 0);
        send_cmd(2'b11);
        check(!dma_en, "R1", "reserved code leaves flag", int'(dma_en), 0);
        send_cmd(2'b01);
        check(dma_en, "R1", "arm command sets flag", int'(dma_en), 1);

        // R2/R3/R4: first full page
        pulse_start();
        check(busy, "R2", "busy after start", int'(busy), 1);
        wait_done(1);
        check(total_strobes == PAGE, "R3", "total after one page", total_strobes, PAGE);
        check(expq.size() == 0, "R4", "all expected bytes consumed", expq.size(), 0);

        // R7: stall with empty FIFOs, then mid-rotation stall
        pulse_start();
        check(busy, "R2", "busy with empty FIFOs", int'(busy), 1);
        tick(20);
        check(busy, "R7", "busy held while starved", int'(busy), 1);
        check(total_strobes == PAGE, "R7", "no strobe while starved", total_strobes, PAGE);
        pulse_start();
        load_bytes(1025);
        tick(1200);
        check(page_strobes == 1025, "R7", "stops at empty FIFO mid-round", page_strobes, 1025);
        check(busy, "R7", "busy held mid-page", int'(busy), 1);
        load_bytes(PAGE - 1025);
        wait_done(2);
        tick(10);
        check(!busy, "R2", "start during busy not queued", int'(busy), 0);
        check(total_strobes == 2 * PAGE, "R2", "two pages moved", total_strobes, 2 * PAGE);

        // R1: disarm blocks start, re-arm allows it
        send_cmd(2'b10);
        check(!dma_en, "R1", "disarm clears flag", int'(dma_en), 0);
        load_bytes(PAGE);
        pulse_start();
        tick(10);
        check(!busy, "R1", "start ignored after disarm", int'(busy), 0);
        check(total_strobes == 2 * PAGE, "R1", "no strobes after disarm",
              total_strobes, 2 * PAGE);
        send_cmd(2'b01);
        pulse_start();
        wait_done(3);
        check(!last_batch, "R9", "no batch mark on third page", int'(last_batch), 0);

        // R8: interrupt on half-full rise only
        half_full = 1'b1;
        tick(10);
        check(irq_count == 1, "R8", "one irq for held half-full", irq_count, 1);
        half_full = 1'b0;
        tick(3);
        check(irq_count == 1, "R8", "no irq on fall", irq_count, 1);
        half_full = 1'b1;
        tick(5);
        check(irq_count == 2, "R8", "irq on second rise", irq_count, 2);

        // R9: batch of pages after the interrupt
        for (int k = 1; k <= PPI; k++) begin
            load_bytes(PAGE);
            pulse_start();
            wait_done(3 + k);
            check(last_batch == (k == PPI), "R9", "batch mark at page of batch",
                  int'(last_batch), int'(k == PPI));
        end
        tick(5);
        check(total_strobes == (3 + PPI) * PAGE, "R3", "grand total",
              total_strobes, (3 + PPI) * PAGE);
        finish_run();
    end

endmodule